// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller for a charge-redistribution analog-to-digital converter. It drives an external capacitor-array DAC and reads back an external comparator. While idle it keeps the array tracking the input: the top capacitor is switched to the input and the comparator auto-zero switch is closed. When a start request arrives, it opens both switches so that the input charge is held. It then resolves the result one bit per trial step, beginning at the most significant bit. When the last bit is decided, it latches the result, lets the array track again, and then drops its busy flag.

The length select is sampled at the start request. When low, all twelve bits are resolved. When high, the conversion is cut short after eight bits and the four low result bits are zero. The mode select is also sampled at start. In immediate mode the hold begins on the cycle after the start request. In delayed mode the array keeps tracking for a fixed number of acquisition cycles before the hold. The acquisition window and the cycles per trial are both parameters. There is no back-pressure. The result is a plain register, valid while the single-cycle `done_o` pulse is high, and it holds its value until the next conversion completes.

Top module: `sar_seq_top`

## Requirements
- R1: During reset and in the first cycle after it, `busy_o` is 0, `done_o` is 0, `result_o` is 0, and both `samp_sw_o` and `az_sw_o` are 1.
- R2: While `busy_o` is 0, `samp_sw_o` and `az_sw_o` are 1 and `dac_word_o` is 0. The result does not follow changes at the comparator.
- R3: In immediate mode (`emul_i`=0), a start request sampled while idle gives, on the next cycle, `busy_o`=1, `samp_sw_o`=0, `az_sw_o`=0 and a first trial word of only the top bit (0x800 for 12 bits).
- R4: Bits are resolved from MSB down, each over `STEP_CYC` cycles. The trial word is the bits already kept plus the current bit. A bit is kept when `cmp_i` is 1 in the last cycle of its step. With `cmp_i` = (trial word <= input code), the 12-bit result equals the input code.
- R5: With `short_i`=1 at start, only the top 8 bits are resolved. The low 4 result bits are 0, and `busy_o` stays high for 8*`STEP_CYC`+1 cycles (plus the acquisition window in delayed mode).
- R6: A 12-bit conversion in immediate mode keeps `busy_o` high for exactly 12*`STEP_CYC`+1 cycles.
- R7: In delayed mode (`emul_i`=1), `busy_o` rises on the cycle after the start request, and the switches stay closed for `ACQ_CYC` cycles. The hold and the first trial then begin, which adds `ACQ_CYC` cycles to the busy time.
- R8: `done_o` is high for exactly one cycle per conversion. In that cycle the new result is on `result_o`, `busy_o` is still 1, and `samp_sw_o` and `az_sw_o` are already 1. `busy_o` falls on the next cycle.
- R9: Start requests while `busy_o` is 1 are ignored. The conversion is neither restarted nor shortened, and the result is unchanged.
- R10: `short_i` and `emul_i` are used only at the start request, so a change during a conversion has no effect. `result_o` changes only together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled on each rising edge |
| short_i | input | 1 | 1 = 8-bit short conversion, 0 = full length |
| emul_i | input | 1 | 1 = acquisition delay before hold, 0 = immediate hold |
| cmp_i | input | 1 | Comparator: 1 = trial level not above the held input |
| dac_word_o | output | NBITS | Trial word to the capacitor array (0 when not trialling) |
| samp_sw_o | output | 1 | 1 = top capacitor connected to the input |
| az_sw_o | output | 1 | 1 = comparator auto-zero switch closed |
| busy_o | output | 1 | Status, high for the whole conversion |
| done_o | output | 1 | One-cycle pulse with the result latch |
| result_o | output | NBITS | Last conversion result |

## Verification
The hardest situation to reach is a change at the inputs in the middle of a conversion. This covers a second start request, and a flip of the length select after the first trial has begun. Both must leave the cycle count and the result untouched. The stimulus injects these events at fixed cycle offsets inside the busy window of a running conversion. It then compares the busy length and the result against values computed from the original settings. A comparator model that compares the trial word with a held input code makes every result predictable, including the forced-zero low bits of a short conversion.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_TRACK = 2'd0,
    ST_ACQ   = 2'd1,
    ST_TRIAL = 2'd2,
    ST_DONE  = 2'd3
  } sar_state_e;
endpackage

// File: rtl/sar_step_timer.sv
// Shared down-counter: loaded with (cycles-1), reports expiry at zero.
module sar_step_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/sar_bit_reg.sv
// Approximation bits plus a one-hot pointer at the bit under trial.
module sar_bit_reg #(
  parameter int NBITS = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             decide_i,
  input  logic             cmp_i,
  output logic [NBITS-1:0] ptr_o,
  output logic [NBITS-1:0] trial_o,
  output logic [NBITS-1:0] next_o
);
  localparam logic [NBITS-1:0] TOP_HOT = {1'b1, {(NBITS-1){1'b0}}};

  logic [NBITS-1:0] appr_q;
  logic [NBITS-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ptr_q <= '0;
    else if (clr_i)    ptr_q <= TOP_HOT;
    else if (decide_i) ptr_q <= ptr_q >> 1;
  end

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      appr_q[i] <= 1'b0;
      else if (clr_i)                  appr_q[i] <= 1'b0;
      else if (decide_i && ptr_q[i])   appr_q[i] <= cmp_i;
    end
  end

  assign ptr_o   = ptr_q;
  assign trial_o = appr_q | ptr_q;
  assign next_o  = appr_q | (cmp_i ? ptr_q : '0);
endmodule

// File: rtl/sar_seq_ctrl.sv
// Conversion state machine: track, optional acquisition, trials, done.
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int ACQ_CYC  = 4,
  parameter int STEP_CYC = 2,
  parameter int CW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          short_i,
  input  logic          emul_i,
  input  logic          expire_i,
  input  logic          last_full_i,
  input  logic          last_short_i,
  output sar_state_e    state_o,
  output logic          clr_o,
  output logic          decide_o,
  output logic          latch_o,
  output logic          load_o,
  output logic [CW-1:0] load_val_o
);
  localparam logic [CW-1:0] ACQ_LOAD  = CW'(ACQ_CYC - 1);
  localparam logic [CW-1:0] STEP_LOAD = CW'(STEP_CYC - 1);

  sar_state_e state_q, state_d;
  logic       short_q;
  logic       last_bit;

  assign last_bit = short_q ? last_short_i : last_full_i;

  always_comb begin
    state_d    = state_q;
    clr_o      = 1'b0;
    decide_o   = 1'b0;
    latch_o    = 1'b0;
    load_o     = 1'b0;
    load_val_o = STEP_LOAD;
    unique case (state_q)
      ST_TRACK: begin
        if (start_i) begin
          clr_o  = 1'b1;
          load_o = 1'b1;
          if (emul_i) begin
            state_d    = ST_ACQ;
            load_val_o = ACQ_LOAD;
          end else begin
            state_d = ST_TRIAL;
          end
        end
      end
      ST_ACQ: begin
        if (expire_i) begin
          state_d = ST_TRIAL;
          load_o  = 1'b1;
        end
      end
      ST_TRIAL: begin
        if (expire_i) begin
          decide_o = 1'b1;
          if (last_bit) begin
            state_d = ST_DONE;
            latch_o = 1'b1;
          end else begin
            load_o = 1'b1;
          end
        end
      end
      ST_DONE: state_d = ST_TRACK;
      default: state_d = ST_TRACK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_TRACK;
      short_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_TRACK && start_i) short_q <= short_i;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_seq_pkg::*;
#(
  parameter int NBITS      = 12,
  parameter int SHORT_BITS = 8,
  parameter int ACQ_CYC    = 4,
  parameter int STEP_CYC   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             short_i,
  input  logic             emul_i,
  input  logic             cmp_i,
  output logic [NBITS-1:0] dac_word_o,
  output logic             samp_sw_o,
  output logic             az_sw_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [NBITS-1:0] result_o
);
  localparam int TMAX       = (ACQ_CYC > STEP_CYC) ? ACQ_CYC : STEP_CYC;
  localparam int CW         = $clog2(TMAX + 1);
  localparam int SHORT_STOP = NBITS - SHORT_BITS;
  localparam logic [NBITS-1:0] SHORT_MASK =
    {{SHORT_BITS{1'b1}}, {SHORT_STOP{1'b0}}};

  sar_state_e       state;
  logic             clr, decide, latch, load, expire, short_run;
  logic [CW-1:0]    load_val;
  logic [NBITS-1:0] ptr, trial, next_word;
  logic [NBITS-1:0] result_q;

  sar_seq_ctrl #(
    .ACQ_CYC (ACQ_CYC),
    .STEP_CYC(STEP_CYC),
    .CW      (CW)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .short_i     (short_i),
    .emul_i      (emul_i),
    .expire_i    (expire),
    .last_full_i (ptr[0]),
    .last_short_i(ptr[SHORT_STOP]),
    .state_o     (state),
    .clr_o       (clr),
    .decide_o    (decide),
    .latch_o     (latch),
    .load_o      (load),
    .load_val_o  (load_val)
  );

  sar_step_timer #(.CW(CW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .load_val_i(load_val),
    .expire_o  (expire)
  );

  sar_bit_reg #(.NBITS(NBITS)) u_bits (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr),
    .decide_i(decide),
    .cmp_i   (cmp_i),
    .ptr_o   (ptr),
    .trial_o (trial),
    .next_o  (next_word)
  );

  // Short runs stop with the pointer on the last kept bit; mask the rest.
  assign short_run = ptr[SHORT_STOP] && (SHORT_STOP != 0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     result_q <= '0;
    else if (latch) result_q <= short_run ? (next_word & SHORT_MASK) : next_word;
  end

  assign dac_word_o = (state == ST_TRIAL) ? trial : '0;
  assign samp_sw_o  = (state != ST_TRIAL);
  assign az_sw_o    = (state != ST_TRIAL);
  assign busy_o     = (state != ST_TRACK);
  assign done_o     = (state == ST_DONE);
  assign result_o   = result_q;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int NBITS = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             emul_i,
  input logic [NBITS-1:0] dac_word_o,
  input logic             samp_sw_o,
  input logic             az_sw_o,
  input logic             busy_o,
  input logic             done_o,
  input logic [NBITS-1:0] result_o
);
  localparam logic [NBITS-1:0] TOP_HOT = {1'b1, {(NBITS-1){1'b0}}};

  assert_idle_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (samp_sw_o && az_sw_o && dac_word_o == '0));

  assert_hold_now_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && !emul_i) |=>
      (busy_o && !samp_sw_o && !az_sw_o && dac_word_o == TOP_HOT));

  assert_trial_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !samp_sw_o) |-> (dac_word_o != '0));

  assert_acq_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i && emul_i) |=> (busy_o && samp_sw_o && az_sw_o));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (busy_o && samp_sw_o && az_sw_o));

  assert_busy_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(done_o));

  assert_no_cut_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o) |=> busy_o);

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));
endmodule

bind sar_seq_top sar_seq_chk #(.NBITS(NBITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .emul_i    (emul_i),
  .dac_word_o(dac_word_o),
  .samp_sw_o (samp_sw_o),
  .az_sw_o   (az_sw_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .result_o  (result_o)
);

// File: tb/sim_sar_seq_top.sv
`timescale 1ns/1ps
module sim_sar_seq_top;
  localparam int NB   = 12;
  localparam int ACQ  = 4;
  localparam int STEP = 2;
  localparam int NVEC = 6;

  // {input code, short, emul} and expected result
  localparam logic [13:0] VEC [NVEC] = '{
    {12'hA5C, 1'b0, 1'b0}, {12'hFFF, 1'b0, 1'b0}, {12'h000, 1'b0, 1'b1},
    {12'h7F3, 1'b1, 1'b0}, {12'h801, 1'b1, 1'b1}, {12'h3C6, 1'b0, 1'b1}
  };
  localparam logic [11:0] VEXP [NVEC] = '{
    12'hA5C, 12'hFFF, 12'h000, 12'h7F0, 12'h800, 12'h3C6
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, short_i = 1'b0, emul_i = 1'b0;
  logic [NB-1:0] vin = '0;
  logic cmp;
  logic [NB-1:0] dac_word, result;
  logic samp_sw, az_sw, busy, done;
  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  // Comparator model: trial level not above the held input code.
  assign cmp = (dac_word <= vin);

  sar_seq_top #(.NBITS(NB), .SHORT_BITS(8), .ACQ_CYC(ACQ), .STEP_CYC(STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .short_i(short_i),
    .emul_i(emul_i), .cmp_i(cmp), .dac_word_o(dac_word), .samp_sw_o(samp_sw),
    .az_sw_o(az_sw), .busy_o(busy), .done_o(done), .result_o(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One conversion; mid_start injects a start at cycle 5, flip_len flips short_i at cycle 3.
  task automatic convert(input logic [11:0] code, input bit sh, input bit em,
                         input logic [11:0] exp_res, input bit mid_start,
                         input bit flip_len, input string tag);
    int cnt = 0;
    int dones = 0;
    int exp_len;
    logic [11:0] res_done = '0;
    bit sw_done = 1'b0;
    bit busy_done = 1'b0;
    exp_len = (em ? ACQ : 0) + (sh ? 8 : 12) * STEP + 1;
    vin = code; short_i = sh; emul_i = em;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    while (busy && cnt < 1000) begin
      cnt++;
      if (cnt == 1 && !em) begin
        chk(!samp_sw && !az_sw && dac_word == 12'h800, {tag, " R3 hold+MSB"},
            {samp_sw, az_sw, dac_word}, 12'h800);
      end
      if (em && cnt == ACQ)
        chk(samp_sw && az_sw, {tag, " R7 tracking in window"}, {samp_sw, az_sw}, 3);
      if (em && cnt == ACQ + 1)
        chk(!samp_sw && dac_word == 12'h800, {tag, " R7 hold after window"},
            {samp_sw, dac_word}, 12'h800);
      if (flip_len && cnt == 3) short_i = ~sh;
      if (flip_len && cnt == 4) emul_i = ~em;
      if (mid_start && cnt == 5) start_i = 1'b1;
      if (mid_start && cnt == 6) start_i = 1'b0;
      if (done) begin
        dones++;
        res_done = result;
        sw_done = samp_sw && az_sw;
        busy_done = busy;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(res_done == exp_res, {tag, sh ? " R5 short result" : " R4 result"}, res_done, exp_res);
    chk(cnt == exp_len, {tag, em ? " R7 busy length" : (sh ? " R5 busy length" : " R6 busy length")},
        cnt, exp_len);
    chk(dones == 1 && sw_done && busy_done, {tag, " R8 done pulse"}, dones, 1);
    chk(result == exp_res, {tag, " R10 result held after busy"}, result, exp_res);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && result == 0 && samp_sw && az_sw, "R1 in reset",
        {busy, done, samp_sw, az_sw}, 4'b0011);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && result == 0 && samp_sw && az_sw && dac_word == 0,
        "R1 after reset", {busy, done, result}, 0);

    for (int i = 0; i < NVEC; i++)
      convert(VEC[i][13:2], VEC[i][1], VEC[i][0], VEXP[i], 1'b0, 1'b0, "vec");

    // R2: idle, comparator input changes leave result and switches alone
    vin = 12'h123;
    repeat (4) @(negedge clk);
    chk(samp_sw && az_sw && dac_word == 0 && result == VEXP[NVEC-1],
        "R2 idle ignores comparator", result, VEXP[NVEC-1]);

    // R9: start during conversion ignored
    convert(12'h5A5, 1'b0, 1'b0, 12'h5A5, 1'b1, 1'b0, "R9 restart");
    convert(12'h9E7, 1'b1, 1'b1, 12'h9E0, 1'b1, 1'b0, "R9 restart short");

    // R10: length/mode flipped mid-conversion have no effect
    convert(12'h6B1, 1'b0, 1'b0, 12'h6B1, 1'b0, 1'b1, "R10 flip");
    convert(12'hC3F, 1'b1, 1'b0, 12'hC30, 1'b0, 1'b1, "R10 flip short");

    // R4 boundary: back-to-back conversions, smallest nonzero code
    convert(12'h001, 1'b0, 1'b0, 12'h001, 1'b0, 1'b0, "R4 lsb");
    convert(12'h00F, 1'b1, 1'b0, 12'h000, 1'b0, 1'b0, "R5 low nibble");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule